// File: doc/BRIEF.md
# Periodic Down-Counter Timer with Compare Interrupt

A 32-bit down-counting timer that sits on a simple word-indexed register bus. Software programs a control word, a load value and a compare value. It can read back those three and the live count. The counter advances on a prescaled tick that comes from one of three clock-enable pulse inputs. It either reloads from the load value or wraps through all-ones. Whenever the counter steps onto the compare value, a sticky status flag is raised. A level interrupt follows that flag when both the interrupt enable and the timer enable are set.

Three extra behaviours are built in. An enable-mode bit makes the counter restart from its start value when the timer is switched on. An overwrite bit lets a load write take effect in the counter at once. A software reset bit in the control word clears the timer and keeps the enable, enable-mode and the four low-power control bits. The low-power bits are stored only and have no effect.

Top module: `pit_timer`

## Requirements
- R1: Registers are selected by word index: 0 control, 1 status (flag in bit 0), 2 load, 3 compare, 4 current count. Reads of any other index return 0. Writes to index 4 or to any index above 4 change nothing.
- R2: Control bits 25:24 select the tick pulse input: 01 `tick_pclk`, 10 `tick_fast`, 11 `tick_slow`. With 00 the counter never advances.
- R3: Control bits 15:4 hold a prescale value P. The counter steps once per P+1 selected pulses while enabled. The prescale count restarts whenever the timer is disabled.
- R4: Control bit 0 enables the timer. Each prescaled tick decrements the count by one. From 0, with the reload bit (bit 3) set, the count reloads from the load register.
- R5: From 0, with the reload bit clear, the count wraps to 0xFFFFFFFF.
- R6: A control write that takes bit 0 from 0 to 1 with enable-mode (bit 1) set loads the count with the load value if the written reload bit is set, and with 0xFFFFFFFF otherwise. Without enable-mode the count is kept.
- R7: A load write with the overwrite bit (bit 17) set copies the value into the count in the same cycle. Without it the count is untouched. A write of this kind wins over a tick in the same cycle.
- R8: The status flag is set on the cycle after a tick produces a count equal to the compare value, whatever the interrupt enable (bit 2) is. When a set and a clear fall in the same cycle, the set wins.
- R9: A status write with bit 0 set clears the flag. A status write with bit 0 clear has no effect.
- R10: `irq` is high exactly when the flag, the interrupt enable and the enable bit are all set.
- R11: Control writes keep bits 25:0 only. A control write with bit 16 set keeps written bits 0, 1 and 18 to 21 and clears every other control bit, bit 16 included. It also clears the flag and compare, and sets load and count to 0xFFFFFFFF.
- R12: Hardware reset clears control, flag and compare, and sets load and count to 0xFFFFFFFF.
- R13: While the timer is disabled and no write targets it, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| tick_pclk | input | 1 | Tick pulse source 1 |
| tick_fast | input | 1 | Tick pulse source 2 |
| tick_slow | input | 1 | Tick pulse source 3 |
| irq | output | 1 | Level compare interrupt |

## Verification
The hardest case to reach is the counter passing through zero. From reset the count starts at 0xFFFFFFFF and would need billions of ticks to get there. The stimulus uses the overwrite bit to drop a small value straight into the count while the timer is off, then enables it, so both the wrap and the reload happen within a few dozen cycles. Compare hits that collide with a status write, or with a write that reloads the count, arise because the tick sources keep running on a fixed pattern while register writes land at arbitrary points.

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              tick_pclk,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic              irq
);
  localparam logic [31:0] ALL1 = '1;
  localparam logic [25:0] KEEP = 26'h03C0003;

  logic [25:0] ctl;
  logic        flag;
  logic [31:0] ldv, cmpv, cnt;
  logic [11:0] div;
  logic        sel_tick;

  wire en   = ctl[0];
  wire ie   = ctl[2];
  wire rld  = ctl[3];
  wire ovw  = ctl[17];
  wire [11:0] psc = ctl[15:4];

  wire wr_ctl = wr_en && addr == ADDR_W'(0);
  wire wr_st  = wr_en && addr == ADDR_W'(1);
  wire wr_ld  = wr_en && addr == ADDR_W'(2);
  wire wr_cmp = wr_en && addr == ADDR_W'(3);
  wire srst   = wr_ctl && wdata[16];

  always_comb begin
    case (ctl[25:24])
      2'b01:   sel_tick = tick_pclk;
      2'b10:   sel_tick = tick_fast;
      2'b11:   sel_tick = tick_slow;
      default: sel_tick = 1'b0;
    endcase
  end

  wire        step    = en && sel_tick && (div >= psc);
  wire [31:0] dec     = (cnt == '0) ? (rld ? ldv : ALL1) : cnt - 32'd1;
  wire        en_load = wr_ctl && !wdata[16] && wdata[0] && wdata[1] && !en;
  wire        ov_load = wr_ld && ovw;
  wire        cnt_wr  = srst || en_load || ov_load;
  wire        hit     = step && !cnt_wr && (dec == cmpv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl  <= '0;
      flag <= 1'b0;
      ldv  <= ALL1;
      cmpv <= '0;
      cnt  <= ALL1;
      div  <= '0;
    end else begin
      if (srst)        ctl <= wdata[25:0] & KEEP;
      else if (wr_ctl) ctl <= wdata[25:0];

      if (srst)       ldv <= ALL1;
      else if (wr_ld) ldv <= wdata;

      if (srst)        cmpv <= '0;
      else if (wr_cmp) cmpv <= wdata;

      if (srst)                    flag <= 1'b0;
      else if (hit)                flag <= 1'b1;
      else if (wr_st && wdata[0])  flag <= 1'b0;

      if (srst)         cnt <= ALL1;
      else if (en_load) cnt <= wdata[3] ? ldv : ALL1;
      else if (ov_load) cnt <= wdata;
      else if (step)    cnt <= dec;

      if (!en || srst)  div <= '0;
      else if (sel_tick) div <= (div >= psc) ? '0 : div + 12'd1;
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(0): rdata = {6'b0, ctl};
      ADDR_W'(1): rdata = {31'b0, flag};
      ADDR_W'(2): rdata = ldv;
      ADDR_W'(3): rdata = cmpv;
      ADDR_W'(4): rdata = cnt;
      default:    rdata = '0;
    endcase
  end

  assign irq = flag && ie && en;
endmodule

module pit_timer_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [25:0]       ctl,
  input logic              flag,
  input logic [31:0]       ldv,
  input logic [31:0]       cmpv,
  input logic [31:0]       cnt,
  input logic              irq
);
  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 32'd1));

  assert_free_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cnt == '0 && !ctl[3]) |=> (cnt == '0 || cnt == 32'hFFFF_FFFF));

  assert_zero_write_keeps_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(1) && !wdata[0] && flag) |=> flag);

  assert_disable_drops_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(0) && !wdata[0]) |=> !irq);

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(0) && wdata[16]) |=>
      (!ctl[16] && ldv == 32'hFFFF_FFFF && cmpv == '0 && !flag && cnt == 32'hFFFF_FFFF));

  assert_hold_when_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[0] && !wr_en) |=> $stable(cnt));
endmodule

bind pit_timer pit_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ctl(ctl), .flag(flag), .ldv(ldv), .cmpv(cmpv), .cnt(cnt), .irq(irq)
);

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
  localparam int AW = 4;
  localparam logic [31:0] EN = 32'h1, ENM = 32'h2, IE = 32'h4, RLD = 32'h8;
  localparam logic [31:0] SWR = 32'h1_0000, OVW = 32'h2_0000;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic tick_pclk = 0, tick_fast = 0, tick_slow = 0, irq;

  pit_timer #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick_pclk(tick_pclk), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .irq(irq)
  );

  always #10 clk = ~clk;

  int vectors = 0, errors = 0, tcnt = 0, rot = 0;
  string req = "R12";
  bit done = 0;

  // reference state
  logic [31:0] m_cr, m_lr, m_cmp, m_cnt;
  bit m_sr;
  int m_div;

  function automatic logic [31:0] psc_of(int p); return 32'(p) << 4; endfunction
  function automatic logic [31:0] src_of(int s); return 32'(s) << 24; endfunction

  function automatic logic [31:0] m_read(logic [AW-1:0] a);
    case (int'(a))
      0: return m_cr;
      1: return {31'b0, m_sr};
      2: return m_lr;
      3: return m_cmp;
      4: return m_cnt;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cr = 0; m_sr = 0; m_lr = 32'hFFFF_FFFF; m_cmp = 0; m_cnt = 32'hFFFF_FFFF; m_div = 0;
    end else begin
      bit avail, fire, match, loaded;
      logic [31:0] nc;
      case (m_cr[25:24])
        2'd1: avail = tick_pclk;
        2'd2: avail = tick_fast;
        2'd3: avail = tick_slow;
        default: avail = 0;
      endcase
      fire = m_cr[0] && avail && (m_div >= int'(m_cr[15:4]));
      if (!m_cr[0]) m_div = 0;
      else if (avail) m_div = fire ? 0 : m_div + 1;
      nc = m_cnt;
      if (fire) nc = (m_cnt == 0) ? (m_cr[3] ? m_lr : 32'hFFFF_FFFF) : m_cnt - 1;
      match = fire && (nc == m_cmp);
      loaded = 0;
      if (wr_en) begin
        case (int'(addr))
          0: if (wdata[16]) begin
               m_cr = wdata & 32'h003C_0003; m_sr = 0; m_cmp = 0;
               m_lr = 32'hFFFF_FFFF; m_cnt = 32'hFFFF_FFFF; m_div = 0; loaded = 1; match = 0;
             end else begin
               if (wdata[0] && !m_cr[0] && wdata[1]) begin
                 m_cnt = wdata[3] ? m_lr : 32'hFFFF_FFFF; loaded = 1;
               end
               m_cr = wdata & 32'h03FF_FFFF;
             end
          1: if (wdata[0] && !match) m_sr = 0;
          2: begin
               if (m_cr[17]) begin m_cnt = wdata; loaded = 1; end
               m_lr = wdata;
             end
          3: m_cmp = wdata;
          default: ;
        endcase
      end
      if (!loaded) begin
        m_cnt = nc;
        if (match) m_sr = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] exp_d;
      logic exp_i;
      exp_d = m_read(addr);
      exp_i = m_sr && m_cr[2] && m_cr[0];
      vectors++;
      if (rdata !== exp_d || irq !== exp_i) begin
        errors++;
        $display("FAIL %s addr=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                 req, addr, rdata, irq, exp_d, exp_i);
      end
    end
  end

  always @(negedge clk) begin
    #1;
    tcnt++;
    tick_pclk = (tcnt % 7) != 0;
    tick_fast = (tcnt % 2) == 0;
    tick_slow = (tcnt % 9) == 0;
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      wr_en = 0; addr = AW'(rot % 8); rot++;
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); #2;
    wr_en = 1; addr = AW'(a); wdata = d;
    @(negedge clk); #2;
    wr_en = 0; addr = AW'(rot % 8); rot++;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired in %s", req);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    req = "R12"; idle(12);
    req = "R1";  wr(5, 32'hDEAD_BEEF); wr(7, 32'h1); wr(15, 32'h55); wr(4, 32'h1234); idle(10);
    req = "R11"; wr(0, 32'hFFFE_FFF0); idle(8);
    wr(3, 55); wr(2, 99); wr(0, 32'h003F_FFFF); idle(8); wr(0, 0); idle(4);
    req = "R3";  wr(2, 20); wr(0, EN | ENM | RLD | psc_of(2) | src_of(1)); idle(80);
    req = "R2";  wr(0, EN | ENM | RLD | src_of(2)); idle(60);
    wr(0, EN | ENM | RLD | src_of(3)); idle(60);
    wr(0, EN | ENM | RLD | src_of(0)); idle(20);
    req = "R4";  wr(0, EN | RLD | src_of(1)); idle(50);
    req = "R8";  wr(3, 5); wr(0, EN | RLD | src_of(1)); idle(40);
    req = "R10"; wr(0, EN | RLD | IE | src_of(1)); idle(10);
    req = "R9";  wr(1, 0); idle(4); wr(1, 1); idle(30);
    req = "R10"; wr(0, IE | RLD | src_of(1)); idle(8);
    req = "R7";  wr(0, OVW | src_of(1)); wr(2, 3); idle(4);
    req = "R5";  wr(0, EN | OVW | src_of(1)); idle(14);
    req = "R7";  wr(0, EN | src_of(1)); wr(2, 7); idle(10);
    req = "R13"; wr(0, src_of(1)); idle(12);
    req = "R6";  wr(0, EN | ENM | src_of(1)); idle(6);
    wr(0, 0); wr(2, 9); wr(0, EN | ENM | RLD | IE | psc_of(4) | src_of(1)); idle(60);
    wr(0, RLD | src_of(1)); wr(0, EN | RLD | src_of(1)); idle(6);
    req = "R11"; wr(0, SWR | EN | IE | src_of(1)); idle(8);
    req = "R12"; wr(0, EN | RLD | src_of(1)); wr(3, 77); idle(5);
    @(negedge clk); #5 rst_n = 0;
    repeat (2) @(negedge clk);
    #2 rst_n = 1;
    idle(10);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule